// File: doc/BRIEF.md
# Low-Power Clock Enable Controller

This block governs the sleep states of a small microcontroller and produces the clock enables that those states gate. It works on the processor clock coming from the PLL. A narrow write port sets the sleep request bits, a per-peripheral enable mask, the peripheral clock ratio and the source of the real-time counter clock. The block then drives enables for the processor, for memory and bus logic, for each peripheral, for the real-time counter and for the oscillator, plus a one-cycle strobe that marks each divided peripheral clock edge.

There are two sleep depths. In the light one only the processor and the memory/bus enables drop. The peripheral strobe and the peripheral enables keep running, so peripherals can raise interrupts that end the sleep. In the deep one every enable drops, the oscillator included, and all state is frozen. The block leaves this state only on reset or on a clock-free wake line, and that line re-enables the oscillator through a purely combinational path. The processor enable then returns only after a warm-up count of oscillator cycles. The real-time counter keeps its enable in deep sleep only when its external low-frequency source is selected.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After a synchronous reset, cpu_en, mem_bus_en, rtc_en and osc_en are 1, periph_en is all ones, pclk_en is 0, the ratio code is 0 and the RTC source is internal.
- R2: A write to address 0 with bit 0 set and bit 1 clear, while running, drops cpu_en and mem_bus_en from the next cycle. periph_en and the pclk_en strobe continue during light sleep.
- R3: Light sleep ends on the first cycle in which any bit of irq or wake_async is high. cpu_en and mem_bus_en return after that edge, and the request does not re-arm by itself.
- R4: A write to address 0 with bit 1 set enters deep sleep, whatever bit 0 holds. From the next cycle cpu_en, mem_bus_en, periph_en, pclk_en and osc_en are all 0.
- R5: In deep sleep, irq has no effect. osc_en rises combinationally, in the same cycle, when any wake_async bit goes high.
- R6: The first clock edge that sees wake_async in deep sleep starts a warm-up. cpu_en becomes 1 after edge STARTUP_CYC+1 counted from that edge, and stays 0 before it.
- R7: Address 1 holds the per-peripheral enable mask, bit i for peripheral i. In run and light sleep, periph_en equals the mask, one cycle after the write takes effect.
- R8: Address 2 bits [1:0] select the ratio: code 1 gives a strobe on every cycle, code 2 every 2nd cycle, and codes 0 and 3 every 4th cycle. Code 0 is the reset value.
- R9: A new ratio takes effect only at the next strobe. The gap that follows a strobe equals the ratio that was selected when that strobe was issued.
- R10: Address 3 bit 0 set selects the external RTC source. In deep sleep and warm-up, rtc_en equals that bit; in run and light sleep it is 1.
- R11: Writes are ignored while not running. All register contents are kept through both sleep states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock from the PLL |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DW | Write data |
| irq | input | NIRQ | Enabled synchronous interrupt requests |
| wake_async | input | NWAKE | Clock-free wake requests |
| cpu_en | output | 1 | Processor clock enable |
| mem_bus_en | output | 1 | Memory and internal bus clock enable |
| periph_en | output | NPERIPH | Per-peripheral clock enables |
| pclk_en | output | 1 | Divided peripheral clock strobe |
| rtc_en | output | 1 | Real-time counter clock enable |
| osc_en | output | 1 | Oscillator enable |

## Verification
A corrupted sleep state shows at the ports within one cycle: cpu_en and the peripheral enables take a pattern that no legal state produces, or osc_en falls while the processor is still enabled. A wrong warm-up count moves the cpu_en rising edge away from its fixed offset after the wake edge. A divider count that slips changes the spacing of pclk_en strobes at the very next strobe. A lost mask, ratio or RTC-source value is exposed on the first cycle after a wake, when periph_en, the strobe rate or rtc_en is compared with the values written before the sleep.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_PDOWN = 2'd2,
    ST_WARM  = 2'd3
  } lpm_state_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_PEN  = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;
  localparam logic [1:0] ADDR_RTC  = 2'd3;

  // reload value of the divider count: ratio minus one
  function automatic logic [1:0] div_reload(input logic [1:0] code);
    case (code)
      2'd1:    div_reload = 2'd0;
      2'd2:    div_reload = 2'd1;
      default: div_reload = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/lpm_regs.sv
module lpm_regs #(
  parameter int NPERIPH = 8,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               accept,
  output logic [NPERIPH-1:0] periph_mask,
  output logic [1:0]         div_sel,
  output logic               rtc_ext,
  output logic               idle_wr,
  output logic               pdown_wr
);
  import lpm_pkg::*;

  logic wr_ok;
  assign wr_ok    = wr_en && accept;
  assign pdown_wr = wr_ok && (wr_addr == ADDR_MODE) && wr_data[1];
  assign idle_wr  = wr_ok && (wr_addr == ADDR_MODE) && wr_data[0] && !wr_data[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      periph_mask <= '1;
      div_sel     <= 2'd0;
      rtc_ext     <= 1'b0;
    end else if (wr_ok) begin
      case (wr_addr)
        ADDR_PEN: periph_mask <= wr_data[NPERIPH-1:0];
        ADDR_DIV: div_sel     <= wr_data[1:0];
        ADDR_RTC: rtc_ext     <= wr_data[0];
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq #(
  parameter int NIRQ        = 4,
  parameter int NWAKE       = 2,
  parameter int STARTUP_CYC = 4096
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                idle_wr,
  input  logic                pdown_wr,
  input  logic [NIRQ-1:0]     irq,
  input  logic [NWAKE-1:0]    wake_async,
  output lpm_pkg::lpm_state_e state_q,
  output lpm_pkg::lpm_state_e state_nx,
  output logic                osc_en
);
  import lpm_pkg::*;

  localparam int CW = (STARTUP_CYC > 1) ? $clog2(STARTUP_CYC) : 1;
  localparam logic [CW-1:0] WARM_LAST = CW'(STARTUP_CYC - 1);

  logic          wake_any;
  logic          irq_any;
  logic [CW-1:0] warm_cnt;

  assign wake_any = |wake_async;
  assign irq_any  = |irq;

  // clock-free path: the oscillator comes back without any clock edge
  assign osc_en = (state_q != ST_PDOWN) || wake_any;

  always_comb begin
    state_nx = state_q;
    case (state_q)
      ST_RUN: begin
        if (pdown_wr)     state_nx = ST_PDOWN;
        else if (idle_wr) state_nx = ST_IDLE;
      end
      ST_IDLE:  if (irq_any || wake_any) state_nx = ST_RUN;
      ST_PDOWN: if (wake_any) state_nx = ST_WARM;
      ST_WARM:  if (warm_cnt == WARM_LAST) state_nx = ST_RUN;
      default:  state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_RUN;
      warm_cnt <= '0;
    end else begin
      state_q <= state_nx;
      if (state_q == ST_PDOWN)     warm_cnt <= '0;
      else if (state_q == ST_WARM) warm_cnt <= warm_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/lpm_pclk_div.sv
module lpm_pclk_div (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] div_sel,
  output logic       tick_q
);
  import lpm_pkg::*;

  logic [1:0] dcnt;

  // the ratio is sampled only when a strobe is issued, so no short period
  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt   <= 2'd0;
      tick_q <= 1'b0;
    end else if (run) begin
      if (dcnt == 2'd0) begin
        tick_q <= 1'b1;
        dcnt   <= div_reload(div_sel);
      end else begin
        tick_q <= 1'b0;
        dcnt   <= dcnt - 1'b1;
      end
    end else begin
      tick_q <= 1'b0;
    end
  end

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl #(
  parameter int NPERIPH     = 8,
  parameter int NIRQ        = 4,
  parameter int NWAKE       = 2,
  parameter int DW          = 8,
  parameter int STARTUP_CYC = 4096
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [NIRQ-1:0]    irq,
  input  logic [NWAKE-1:0]   wake_async,
  output logic               cpu_en,
  output logic               mem_bus_en,
  output logic [NPERIPH-1:0] periph_en,
  output logic               pclk_en,
  output logic               rtc_en,
  output logic               osc_en
);
  import lpm_pkg::*;

  logic [NPERIPH-1:0] periph_mask;
  logic [1:0]         div_sel;
  logic               rtc_ext;
  logic               idle_wr;
  logic               pdown_wr;
  lpm_state_e         state_q;
  lpm_state_e         state_nx;
  logic               active_nx;

  lpm_regs #(.NPERIPH(NPERIPH), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .accept(state_q == ST_RUN), .periph_mask(periph_mask), .div_sel(div_sel),
    .rtc_ext(rtc_ext), .idle_wr(idle_wr), .pdown_wr(pdown_wr)
  );

  lpm_seq #(.NIRQ(NIRQ), .NWAKE(NWAKE), .STARTUP_CYC(STARTUP_CYC)) u_seq (
    .clk(clk), .rst(rst), .idle_wr(idle_wr), .pdown_wr(pdown_wr), .irq(irq),
    .wake_async(wake_async), .state_q(state_q), .state_nx(state_nx), .osc_en(osc_en)
  );

  assign active_nx = (state_nx == ST_RUN) || (state_nx == ST_IDLE);

  lpm_pclk_div u_div (
    .clk(clk), .rst(rst), .run(active_nx), .div_sel(div_sel), .tick_q(pclk_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_en     <= 1'b1;
      mem_bus_en <= 1'b1;
      periph_en  <= '1;
      rtc_en     <= 1'b1;
    end else begin
      cpu_en     <= (state_nx == ST_RUN);
      mem_bus_en <= (state_nx == ST_RUN);
      periph_en  <= active_nx ? periph_mask : '0;
      rtc_en     <= active_nx || rtc_ext;
    end
  end

endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk #(
  parameter int NPERIPH = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               cpu_en,
  input logic               mem_bus_en,
  input logic [NPERIPH-1:0] periph_en,
  input logic               pclk_en,
  input logic               rtc_en,
  input logic               osc_en,
  input logic [NPERIPH-1:0] mask_q,
  input logic [1:0]         sel_q,
  input logic               ext_q
);

  a_r4_deep_quiet: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> (!cpu_en && !mem_bus_en && !pclk_en && (periph_en == '0)));

  a_r6_no_early_cpu: assert property (@(posedge clk) disable iff (rst)
    !osc_en |=> !cpu_en);

  a_r6_cpu_after_osc: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_en) |-> $past(osc_en));

  a_r7_mask_respected: assert property (@(posedge clk) disable iff (rst)
    (periph_en & ~$past(mask_q)) == '0);

  a_r9_boundary: assert property (@(posedge clk) disable iff (rst)
    (pclk_en && $past(pclk_en)) |-> ($past(sel_q, 2) == 2'd1));

  a_r10_rtc_deep: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> (rtc_en == ext_q));

endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk #(.NPERIPH(NPERIPH)) u_chk (
  .clk(clk), .rst(rst), .cpu_en(cpu_en), .mem_bus_en(mem_bus_en),
  .periph_en(periph_en), .pclk_en(pclk_en), .rtc_en(rtc_en), .osc_en(osc_en),
  .mask_q(periph_mask), .sel_q(div_sel), .ext_q(rtc_ext)
);

// File: tb/lpm_clk_ctrl_tb.sv
module lpm_clk_ctrl_tb;
  localparam int NP = 8;
  localparam int NI = 4;
  localparam int NW = 2;
  localparam int DW = 8;
  localparam int SC = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NI-1:0] irq = '0;
  logic [NW-1:0] wake_async = '0;
  logic          cpu_en, mem_bus_en, pclk_en, rtc_en, osc_en;
  logic [NP-1:0] periph_en;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lpm_clk_ctrl #(.NPERIPH(NP), .NIRQ(NI), .NWAKE(NW), .DW(DW), .STARTUP_CYC(SC)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq(irq), .wake_async(wake_async), .cpu_en(cpu_en), .mem_bus_en(mem_bus_en),
    .periph_en(periph_en), .pclk_en(pclk_en), .rtc_en(rtc_en), .osc_en(osc_en)
  );

  // reference model built from the requirements: 0 run, 1 light, 2 deep, 3 warm-up
  int            m_st, m_cnt, m_dcnt;
  logic [NP-1:0] m_mask, e_per;
  logic [1:0]    m_sel;
  logic          m_ext, e_cpu, e_pclk, e_rtc;

  function automatic int ratio(input logic [1:0] c);
    return (c == 2'd1) ? 1 : (c == 2'd2) ? 2 : 4;
  endfunction

  always @(posedge clk) begin
    int  nx;
    logic act, ok;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_dcnt = 0; m_mask = '1; m_sel = 0; m_ext = 0;
      e_cpu = 1; e_per = '1; e_pclk = 0; e_rtc = 1;
    end else begin
      nx = m_st;
      ok = wr_en && (m_st == 0);
      case (m_st)
        0: if (ok && wr_addr == 0) begin
             if (wr_data[1]) nx = 2; else if (wr_data[0]) nx = 1;
           end
        1: if ((|irq) || (|wake_async)) nx = 0;
        2: if (|wake_async) begin nx = 3; m_cnt = 0; end
        default: if (m_cnt == SC - 1) nx = 0; else m_cnt = m_cnt + 1;
      endcase
      act = (nx == 0) || (nx == 1);
      if (act) begin
        if (m_dcnt == 0) begin e_pclk = 1; m_dcnt = ratio(m_sel) - 1; end
        else begin e_pclk = 0; m_dcnt = m_dcnt - 1; end
      end else e_pclk = 0;
      e_cpu = (nx == 0);
      e_per = act ? m_mask : '0;
      e_rtc = act || m_ext;
      if (ok) begin
        if (wr_addr == 1) m_mask = wr_data[NP-1:0];
        if (wr_addr == 2) m_sel = wr_data[1:0];
        if (wr_addr == 3) m_ext = wr_data[0];
      end
      m_st = nx;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // at a falling edge: compare everything with the model, then release one-shot inputs
  task automatic cyc();
    @(negedge clk);
    chk("R6/R2/R3 cpu_en", 32'(cpu_en), 32'(e_cpu));
    chk("R2/R4 mem_bus_en", 32'(mem_bus_en), 32'(e_cpu));
    chk("R7 periph_en", 32'(periph_en), 32'(e_per));
    chk("R8/R9 pclk_en", 32'(pclk_en), 32'(e_pclk));
    chk("R10 rtc_en", 32'(rtc_en), 32'(e_rtc));
    chk("R5 osc_en", 32'(osc_en), 32'((m_st != 2) || (|wake_async)));
    wr_en = 0; irq = '0; wake_async = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc();
  endtask

  task automatic gap(output int g);
    g = 0;
    while (!pclk_en) cyc();
    cyc(); g = 1;
    while (!pclk_en && g < 20) begin cyc(); g++; end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int g, n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    cyc();
    chk("R1 reset cpu_en", 32'(cpu_en), 1);
    chk("R1 reset osc_en", 32'(osc_en), 1);
    chk("R1 reset periph_en", 32'(periph_en), 32'hFF);
    gap(g); chk("R8 reset ratio gap", g, 4);
    // ratio codes
    wr(2, 8'd1); gap(g); gap(g); chk("R8 code1 gap", g, 1);
    wr(2, 8'd2); gap(g); gap(g); chk("R8 code2 gap", g, 2);
    wr(2, 8'd3); gap(g); gap(g); chk("R8 code3 gap", g, 4);
    // change right after a strobe: the current gap keeps the old ratio
    while (!pclk_en) cyc();
    wr(2, 8'd1); g = 1;
    while (!pclk_en) begin cyc(); g++; end
    chk("R9 old ratio kept", g, 4);
    cyc(); chk("R9 new ratio used", 32'(pclk_en), 1);
    // mask
    wr(1, 8'hA5); cyc(); chk("R7 mask shown", 32'(periph_en), 32'hA5);
    // light sleep
    wr(0, 8'h01);
    chk("R2 cpu off", 32'(cpu_en), 0);
    n = 0; repeat (6) begin cyc(); n += int'(pclk_en); end
    chk("R2 strobe runs", 32'(n > 0), 1);
    chk("R2 periph kept", 32'(periph_en), 32'hA5);
    wr_en = 1; wr_addr = 1; wr_data = 8'h00; cyc();
    irq = 4'b0100; cyc();
    chk("R3 wake by irq", 32'(cpu_en), 1);
    repeat (3) cyc();
    chk("R3 no re-arm", 32'(cpu_en), 1);
    chk("R11 write in sleep ignored", 32'(periph_en), 32'hA5);
    // deep sleep with priority, irq ignored, external rtc
    wr(3, 8'h01);
    wr(0, 8'h03);
    chk("R4 osc off", 32'(osc_en), 0);
    chk("R4 periph off", 32'(periph_en), 0);
    chk("R10 rtc kept ext", 32'(rtc_en), 1);
    irq = 4'b1111; cyc(); cyc();
    chk("R5 irq ignored", 32'(osc_en | cpu_en), 0);
    wake_async = 2'b10; #1;
    chk("R5 osc comb", 32'(osc_en), 1);
    n = 0;
    cyc(); n = 1;
    while (!cpu_en && n < SC + 10) begin cyc(); n++; end
    chk("R6 warm-up length", n, SC + 1);
    chk("R11 mask held", 32'(periph_en), 32'hA5);
    // deep sleep with internal rtc source
    wr(3, 8'h00); wr(0, 8'h02);
    chk("R10 rtc off internal", 32'(rtc_en), 0);
    wake_async = 2'b01; cyc();
    repeat (SC + 2) cyc();
    chk("R6 back to run", 32'(cpu_en), 1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      if (m_st == 0 && ($urandom % 6) == 0) begin
        wr_en = 1; wr_addr = 2'($urandom % 4);
        wr_data = 8'($urandom);
        if (wr_addr == 0 && ($urandom % 3) != 0) wr_data[1:0] = 2'b00;
      end
      if (($urandom % 12) == 0) irq = 4'($urandom);
      if (($urandom % 24) == 0) wake_async = 2'($urandom);
      cyc();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule